// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Loader

This block takes configuration words for a frequency synthesizer from a three-wire serial link made of a data line, a serial clock and a load strobe. It samples all three lines with the system clock and moves one data bit into a shift register on each rising edge of the serial clock, most significant bit first. A rising edge on the load strobe transfers the word into one of two holding registers. The trailing bit of each word, which lands in bit 0 of the shift register, picks the destination.

A 16-bit word with trailing bit 1 programs the reference side. Bits 14..1 carry the 14-bit reference ratio and bit 15 carries the prescaler modulus choice. A 20-bit word with trailing bit 0 programs the main divider. Bits 8..1 carry the 8-bit swallow count and bits 19..9 carry the 11-bit main count.

A word whose ratio field is below its legal minimum is refused and raises a one-cycle error pulse. A level output that follows the load strobe enables the external loop-filter bypass switch. The dividers themselves lie outside this block.

Top module: `serprog_loader`

## Requirements
- R1: After reset every latched field is zero, both valid flags are low, and load_err and sw_en are low.
- R2: A 16-bit word with bit 0 = 1, followed by a load strobe rising edge, sets ref_ratio to word bits 14..1 and ref_mode to word bit 15.
- R3: A 20-bit word with bit 0 = 0, followed by a load strobe rising edge, sets main_swallow to word bits 8..1 and main_count to word bits 19..9.
- R4: A transfer changes only the holding register named by the trailing bit; the other register keeps its contents.
- R5: A reference word whose ratio is below 8 is not latched. A ratio of 8 is accepted.
- R6: A main word whose count is below 16 is not latched. A count of 16 is accepted.
- R7: Transfer happens only on the rising edge of the load strobe. Serial clocks shifted in while the strobe stays high, and the falling edge of the strobe, leave the latched fields unchanged.
- R8: sw_en is high while the synchronised load strobe is high and low while it is low.
- R9: ref_valid and main_valid rise on the first accepted load of their register and stay high; a refused word does not clear them.
- R10: Bits shifted in ahead of the last 16 (reference) or 20 (main) bits have no effect on the latched fields.
- R11: Each refused word produces exactly one load_err pulse, one system clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe, asynchronous |
| ref_ratio | output | 14 | Latched reference ratio |
| ref_mode | output | 1 | Latched prescaler modulus choice |
| main_swallow | output | 8 | Latched swallow count |
| main_count | output | 11 | Latched main count |
| ref_valid | output | 1 | Reference register holds an accepted word |
| main_valid | output | 1 | Main register holds an accepted word |
| load_err | output | 1 | One-cycle pulse when a word is refused |
| sw_en | output | 1 | Loop-filter switch enable, follows the load strobe |

## Verification
The assertions assume that each serial line holds its level for several system clock cycles, well beyond the synchroniser depth. Under that assumption two load strobe rising edges never reach the latch on consecutive cycles, and no serial clock edge is missed. The bench keeps every serial phase at three system clocks and holds the strobe high for eight, which matches the microsecond setup and hold windows of the link scaled to the system clock. The random words choose their destination and fields freely. About one word in five is pushed below its minimum so that refusals are tested along with accepted loads.

// File: rtl/serprog_pkg.sv
package serprog_pkg;
    parameter int REF_RATIO_W  = 14;
    parameter int SWALLOW_W    = 8;
    parameter int MAIN_COUNT_W = 11;
    parameter int REF_RATIO_MIN  = 8;
    parameter int MAIN_COUNT_MIN = 16;
    parameter int SYNC_STAGES    = 2;

    localparam int REF_WORD_W  = REF_RATIO_W + 2;
    localparam int MAIN_WORD_W = SWALLOW_W + MAIN_COUNT_W + 1;
    localparam int SHIFT_W     = (REF_WORD_W > MAIN_WORD_W) ? REF_WORD_W : MAIN_WORD_W;

    typedef enum logic {
        DEST_MAIN = 1'b0,
        DEST_REF  = 1'b1
    } dest_e;
endpackage

// File: rtl/serprog_sync.sv
module serprog_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign stg_d[g] = din;
        end else begin : g_next
            assign stg_d[g] = stg_q[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q[g] <= '0;
            end else begin
                stg_q[g] <= stg_d[g];
            end
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/serprog_shift.sv
module serprog_shift #(
    parameter int SHIFT_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               sdata_s,
    output logic [SHIFT_W-1:0] word_q
);
    typedef struct packed {
        logic               sclk_prev;
        logic [SHIFT_W-1:0] sr;
    } shift_state_t;

    shift_state_t st_d, st_q;
    logic         sclk_rise;

    assign sclk_rise = sclk_s & ~st_q.sclk_prev;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_s;
        if (sclk_rise) begin
            st_d.sr = {st_q.sr[SHIFT_W-2:0], sdata_s};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_q = st_q.sr;

    // R7
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(word_q));
endmodule

// File: rtl/serprog_latch.sv
module serprog_latch
    import serprog_pkg::*;
#(
    parameter int RATIO_W   = REF_RATIO_W,
    parameter int SWAL_W    = SWALLOW_W,
    parameter int COUNT_W   = MAIN_COUNT_W,
    parameter int RATIO_MIN = REF_RATIO_MIN,
    parameter int COUNT_MIN = MAIN_COUNT_MIN,
    parameter int SHIFT_W   = SWAL_W + COUNT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               le_s,
    input  logic [SHIFT_W-1:0] word,
    output logic [RATIO_W-1:0] ref_ratio,
    output logic               ref_mode,
    output logic [SWAL_W-1:0]  main_swallow,
    output logic [COUNT_W-1:0] main_count,
    output logic               ref_valid,
    output logic               main_valid,
    output logic               load_err,
    output logic               sw_en
);
    localparam logic [RATIO_W-1:0] RATIO_LO = RATIO_W'(RATIO_MIN);
    localparam logic [COUNT_W-1:0] COUNT_LO = COUNT_W'(COUNT_MIN);
    localparam int MODE_BIT  = RATIO_W + 1;
    localparam int COUNT_TOP = SWAL_W + COUNT_W;

    typedef struct packed {
        logic               le_prev;
        logic [RATIO_W-1:0] ratio;
        logic               mode;
        logic [SWAL_W-1:0]  swallow;
        logic [COUNT_W-1:0] count;
        logic               ref_ok;
        logic               main_ok;
        logic               err;
    } latch_state_t;

    latch_state_t st_d, st_q;
    logic               le_rise;
    dest_e              dest;
    logic [RATIO_W-1:0] ratio_in;
    logic [SWAL_W-1:0]  swallow_in;
    logic [COUNT_W-1:0] count_in;

    assign le_rise    = le_s & ~st_q.le_prev;
    assign dest       = dest_e'(word[0]);
    assign ratio_in   = word[RATIO_W:1];
    assign swallow_in = word[SWAL_W:1];
    assign count_in   = word[COUNT_TOP:SWAL_W+1];

    always_comb begin
        st_d         = st_q;
        st_d.le_prev = le_s;
        st_d.err     = 1'b0;
        if (le_rise) begin
            if (dest == DEST_REF) begin
                if (ratio_in >= RATIO_LO) begin
                    st_d.ratio  = ratio_in;
                    st_d.mode   = word[MODE_BIT];
                    st_d.ref_ok = 1'b1;
                end else begin
                    st_d.err = 1'b1;
                end
            end else begin
                if (count_in >= COUNT_LO) begin
                    st_d.swallow = swallow_in;
                    st_d.count   = count_in;
                    st_d.main_ok = 1'b1;
                end else begin
                    st_d.err = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_ratio    = st_q.ratio;
    assign ref_mode     = st_q.mode;
    assign main_swallow = st_q.swallow;
    assign main_count   = st_q.count;
    assign ref_valid    = st_q.ref_ok;
    assign main_valid   = st_q.main_ok;
    assign load_err     = st_q.err;
    assign sw_en        = st_q.le_prev;

    // R7
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !le_rise |=> $stable({ref_ratio, ref_mode, main_swallow, main_count}));
    // R5
    ref_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |-> (ref_ratio >= RATIO_LO));
    // R6
    main_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        main_valid |-> (main_count >= COUNT_LO));
    // R11
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |=> !load_err);
    // R9
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid || main_valid) |=> ($past(ref_valid) -> ref_valid) && ($past(main_valid) -> main_valid));
    // R4
    one_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $changed({ref_ratio, ref_mode}) |-> $stable({main_swallow, main_count}));
endmodule

// File: rtl/serprog_loader.sv
module serprog_loader
    import serprog_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ser_clk,
    input  logic                    ser_data,
    input  logic                    ser_le,
    output logic [REF_RATIO_W-1:0]  ref_ratio,
    output logic                    ref_mode,
    output logic [SWALLOW_W-1:0]    main_swallow,
    output logic [MAIN_COUNT_W-1:0] main_count,
    output logic                    ref_valid,
    output logic                    main_valid,
    output logic                    load_err,
    output logic                    sw_en
);
    localparam int LINES = 3;

    logic [LINES-1:0]   raw_lines;
    logic [LINES-1:0]   sync_lines;
    logic [SHIFT_W-1:0] word_q;

    assign raw_lines = {ser_le, ser_data, ser_clk};

    serprog_sync #(
        .WIDTH  (LINES),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_lines),
        .dout  (sync_lines)
    );

    serprog_shift #(
        .SHIFT_W (SHIFT_W)
    ) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sync_lines[0]),
        .sdata_s (sync_lines[1]),
        .word_q  (word_q)
    );

    serprog_latch #(
        .RATIO_W   (REF_RATIO_W),
        .SWAL_W    (SWALLOW_W),
        .COUNT_W   (MAIN_COUNT_W),
        .RATIO_MIN (REF_RATIO_MIN),
        .COUNT_MIN (MAIN_COUNT_MIN),
        .SHIFT_W   (SHIFT_W)
    ) latch_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .le_s         (sync_lines[2]),
        .word         (word_q),
        .ref_ratio    (ref_ratio),
        .ref_mode     (ref_mode),
        .main_swallow (main_swallow),
        .main_count   (main_count),
        .ref_valid    (ref_valid),
        .main_valid   (main_valid),
        .load_err     (load_err),
        .sw_en        (sw_en)
    );

    // R8
    sw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_en) |-> $past(sync_lines[2]));
endmodule

// File: tb/serprog_loader_tb.sv
module serprog_loader_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_le = 1'b0;
    logic [13:0] ref_ratio;
    logic        ref_mode;
    logic [7:0]  main_swallow;
    logic [10:0] main_count;
    logic        ref_valid, main_valid, load_err, sw_en;

    int checks = 0;
    int errors = 0;
    int err_seen = 0;
    bit done = 1'b0;

    logic [13:0] e_ratio = '0;
    logic        e_mode = 1'b0;
    logic [7:0]  e_swal = '0;
    logic [10:0] e_count = '0;
    logic        e_rv = 1'b0, e_mv = 1'b0;
    int          e_err = 0;

    always #2.5 clk = ~clk;

    serprog_loader dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .ref_ratio(ref_ratio), .ref_mode(ref_mode), .main_swallow(main_swallow),
        .main_count(main_count), .ref_valid(ref_valid), .main_valid(main_valid),
        .load_err(load_err), .sw_en(sw_en)
    );

    always @(negedge clk) if (rst_n && load_err) err_seen++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_word(input logic mode, input logic [13:0] ratio);
        return {mode, ratio, 1'b1};
    endfunction

    function automatic logic [19:0] main_word(input logic [10:0] cnt, input logic [7:0] swal);
        return {cnt, swal, 1'b0};
    endfunction

    task automatic model_load(input logic [31:0] w);
        if (w[0]) begin
            if (w[14:1] >= 14'd8) begin
                e_ratio = w[14:1]; e_mode = w[15]; e_rv = 1'b1;
            end else e_err++;
        end else begin
            if (w[19:9] >= 11'd16) begin
                e_swal = w[8:1]; e_count = w[19:9]; e_mv = 1'b1;
            end else e_err++;
        end
    endtask

    task automatic phase();
        repeat (3) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [31:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = w[i];
            phase();
            ser_clk = 1'b1;
            phase();
            ser_clk = 1'b0;
        end
    endtask

    task automatic strobe();
        ser_le = 1'b1;
        repeat (8) @(negedge clk);
        ser_le = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        check({tag, " R2 ref_ratio"}, 32'(ref_ratio), 32'(e_ratio));
        check({tag, " R2 ref_mode"}, 32'(ref_mode), 32'(e_mode));
        check({tag, " R3 main_swallow"}, 32'(main_swallow), 32'(e_swal));
        check({tag, " R3 main_count"}, 32'(main_count), 32'(e_count));
        check({tag, " R9 valids"}, {30'd0, ref_valid, main_valid}, {30'd0, e_rv, e_mv});
        check({tag, " R11 err pulses"}, 32'(err_seen), 32'(e_err));
    endtask

    task automatic send(input logic [31:0] w, input int n, input string tag);
        shift_bits(w, n);
        model_load(w);
        strobe();
        check_all(tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main_seq
        logic [31:0] rnd;
        rnd = $urandom(32'd1507);
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 fields", {ref_ratio, ref_mode, main_swallow, main_count}, 34'd0);
        check("R1 flags", {28'd0, ref_valid, main_valid, load_err, sw_en}, 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R5 boundary: 7 refused, 8 accepted
        send(32'(ref_word(1'b1, 14'd7)), 16, "R5 ratio7");
        send(32'(ref_word(1'b1, 14'd8)), 16, "R5 ratio8");
        // R6 boundary: 15 refused, 16 accepted
        send(32'(main_word(11'd15, 8'd3)), 20, "R6 count15");
        send(32'(main_word(11'd16, 8'd255)), 20, "R6 count16");
        // R4 other register untouched
        send(32'(ref_word(1'b0, 14'h3FFF)), 16, "R4 ref only");
        check("R4 main kept", 32'(main_count), 32'd16);
        send(32'(main_word(11'h7FF, 8'd0)), 20, "R4 main only");
        check("R4 ref kept", 32'(ref_ratio), 32'h3FFF);
        // R10 leading junk bits
        send({8'hA5, 8'hFF, ref_word(1'b1, 14'd1234)}, 32, "R10 preamble");

        // R7 / R8: held-high strobe, extra clocks, then fall
        ser_le = 1'b1;
        repeat (8) @(negedge clk);
        check("R8 sw_en high", 32'(sw_en), 32'd1);
        shift_bits(32'(ref_word(1'b0, 14'd99)), 16);
        check_all("R7 held high");
        ser_le = 1'b0;
        repeat (8) @(negedge clk);
        check("R8 sw_en low", 32'(sw_en), 32'd0);
        check_all("R7 after fall");

        // random mix
        for (int k = 0; k < 50; k++) begin
            logic [31:0] w;
            rnd = $urandom;
            if (rnd[0]) begin
                logic [13:0] r;
                r = ($urandom % 5 == 0) ? 14'($urandom % 8) : 14'($urandom);
                w = 32'(ref_word(rnd[1], r));
                send(w, 16, "rand ref");
            end else begin
                logic [10:0] c;
                c = ($urandom % 5 == 0) ? 11'($urandom % 16) : 11'($urandom);
                w = 32'(main_word(c, 8'($urandom)));
                send(w, 20, "rand main");
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule